// File: doc/BRIEF.md
# I2C Command Dispatch and Lock Gate

This block stands between the processor's register port and two I2C protocol engines, one acting as bus master and one as slave. Software writes a command word that carries a 5-bit command code and a byte of transmit data. The top bit of the code picks the engine. The gate checks the code against that engine's command set. An accepted command is passed to the engine with a one-cycle strobe, the code's low four bits and the data byte.

Each engine holds at most one command at a time. When a command is accepted, a lock flag for that engine is set. The flag stays set until that engine raises any interrupt, which counts as the acknowledgement. A command is rejected and raises a sticky error flag in three cases: its target is still locked, the code does not belong to the engine it selects, or the code is undefined. Reading the status register clears the error flag. The status register also shows both lock flags and the byte received by the engines.

Master read and write commands are what make the master engine join bus arbitration once the bus is idle. The slave no-op exists to hand a transmit byte to the slave engine without a real command.

Top module: `i2c_cmd_gate`

## Requirements
- R1: While reset is held, and on the first cycle after it, both strobes are low and the master lock, the slave lock and the error flag all read 0.
- R2: The command code is wr_data[12:8] and the data byte is wr_data[7:0]. Bit 12 selects the master (0) or the slave (1). An accepted write raises exactly one strobe, on the cycle after the write and for one cycle. On that cycle cmd_code is the code's low four bits and cmd_data is the data byte.
- R3: The master accepts exactly these codes: 0x00 no-op, 0x04 start read, 0x05 start write and 0x06 stop.
- R4: The slave accepts exactly these codes: 0x10, forwarded as code 0x0 (no-op that carries data), and 0x16, forwarded as code 0x6 (stop by not acknowledging).
- R5: An accepted command sets its engine's lock from the next cycle. The master lock reads at rd_data[8] and the slave lock at rd_data[9].
- R6: An interrupt from an engine clears that engine's lock on the next cycle. If the interrupt comes in the same cycle as an accepted command to that engine, the lock stays set.
- R7: A write to a locked engine produces no strobe and leaves both locks unchanged. From the next cycle it sets the error flag, rd_data[10]. This holds even when an interrupt releases the lock in that same cycle.
- R8: A code outside the selected engine's set is rejected and sets the error flag. This covers slave codes with bit 12 clear, master codes with bit 12 set, and undefined codes. A rejected code produces no strobe and changes no lock.
- R9: The error flag stays set until rd_en is asserted, and it reads 0 from the cycle after that. If a rejected write comes in the same cycle as rd_en, the flag stays set.
- R10: rd_data[7:0] follows rx_data in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Command register write strobe |
| wr_data | input | 13 | Command code [12:8] and transmit byte [7:0] |
| rd_en | input | 1 | Status register read strobe; clears the error flag |
| rd_data | output | 11 | Error flag [10], slave lock [9], master lock [8], receive byte [7:0] |
| rx_data | input | 8 | Receive byte from the engines |
| m_irq | input | 1 | Any interrupt from the master engine |
| s_irq | input | 1 | Any interrupt from the slave engine |
| m_cmd_vld | output | 1 | One-cycle command strobe to the master engine |
| s_cmd_vld | output | 1 | One-cycle command strobe to the slave engine |
| cmd_code | output | 4 | Low four bits of the forwarded command code |
| cmd_data | output | 8 | Transmit byte forwarded with the command |

## Verification
Strobes, forwarded code and data, lock changes and error setting all appear one register stage after the write or interrupt, so they are due on the cycle after the rising edge that samples the stimulus. The error flag clears on the cycle after the read strobe. The receive byte passes through combinationally in the same cycle. The bench's reference model advances on the rising edge. Inputs change just after the falling edge, and every output is compared with the model at the falling edge, half a cycle after the edge on which each result is due.

// File: rtl/i2c_cmd_gate.sv
module i2c_cmd_gate #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [DATA_W+CODE_W-1:0] wr_data,
  input  logic                     rd_en,
  output logic [DATA_W+2:0]        rd_data,
  input  logic [DATA_W-1:0]        rx_data,
  input  logic                     m_irq,
  input  logic                     s_irq,
  output logic                     m_cmd_vld,
  output logic                     s_cmd_vld,
  output logic [CODE_W-2:0]        cmd_code,
  output logic [DATA_W-1:0]        cmd_data
);
  localparam int WR_W = DATA_W + CODE_W;
  localparam int LW   = CODE_W - 1;
  localparam logic [LW-1:0] OP_NOP   = LW'(0);
  localparam logic [LW-1:0] OP_READ  = LW'(4);
  localparam logic [LW-1:0] OP_WRITE = LW'(5);
  localparam logic [LW-1:0] OP_STOP  = LW'(6);

  logic          to_slave;
  logic [LW-1:0] op;
  logic          m_legal, s_legal, take_m, take_s, reject;
  logic          m_lock, s_lock, err;

  assign to_slave = wr_data[WR_W-1];
  assign op       = wr_data[WR_W-2:DATA_W];

  assign m_legal = !to_slave &&
                   (op == OP_NOP || op == OP_READ || op == OP_WRITE || op == OP_STOP);
  assign s_legal = to_slave && (op == OP_NOP || op == OP_STOP);

  assign take_m = wr_en && m_legal && !m_lock;
  assign take_s = wr_en && s_legal && !s_lock;
  assign reject = wr_en && !take_m && !take_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lock    <= 1'b0;
      s_lock    <= 1'b0;
      err       <= 1'b0;
      m_cmd_vld <= 1'b0;
      s_cmd_vld <= 1'b0;
      cmd_code  <= '0;
      cmd_data  <= '0;
    end else begin
      m_lock    <= take_m | (m_lock & ~m_irq);
      s_lock    <= take_s | (s_lock & ~s_irq);
      err       <= reject | (err & ~rd_en);
      m_cmd_vld <= take_m;
      s_cmd_vld <= take_s;
      if (take_m || take_s) begin
        cmd_code <= op;
        cmd_data <= wr_data[DATA_W-1:0];
      end
    end
  end

  assign rd_data = {err, s_lock, m_lock, rx_data};
endmodule

// File: rtl/i2c_cmd_gate_chk.sv
module i2c_cmd_gate_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic              m_irq,
  input logic              s_irq,
  input logic              m_cmd_vld,
  input logic              s_cmd_vld,
  input logic [DATA_W+2:0] rd_data
);
  logic ml, sl, er;
  assign ml = rd_data[DATA_W];
  assign sl = rd_data[DATA_W+1];
  assign er = rd_data[DATA_W+2];

  p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m_cmd_vld, s_cmd_vld}));
  p_strobe_from_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_cmd_vld || s_cmd_vld) |-> $past(wr_en));
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    m_cmd_vld |=> !m_cmd_vld);
  p_mstrobe_locks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_cmd_vld |-> ml);
  p_sstrobe_locks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_cmd_vld |-> sl);
  p_mstrobe_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_cmd_vld |-> !$past(ml));
  p_sstrobe_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    s_cmd_vld |-> !$past(sl));
  p_mrelease_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ml) |-> $past(m_irq));
  p_srelease_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sl) |-> $past(s_irq));
  p_err_from_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(er) |-> $past(wr_en));
  p_err_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en) && !$past(wr_en)) |-> !er);
endmodule

bind i2c_cmd_gate i2c_cmd_gate_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .m_irq(m_irq), .s_irq(s_irq), .m_cmd_vld(m_cmd_vld),
  .s_cmd_vld(s_cmd_vld), .rd_data(rd_data)
);

// File: tb/i2c_cmd_gate_bench.sv
module i2c_cmd_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, m_irq = 1'b0, s_irq = 1'b0;
  logic [12:0] wr_data = '0;
  logic [7:0]  rx_data = '0;
  logic [10:0] rd_data;
  logic        m_cmd_vld, s_cmd_vld;
  logic [3:0]  cmd_code;
  logic [7:0]  cmd_data;

  int vectors = 0, errors = 0;
  bit done = 0;

  i2c_cmd_gate u_i2c_cmd_gate (.*);

  always #10 clk = ~clk;

  // behavioural reference state
  bit e_ml, e_sl, e_er, e_mv, e_sv;
  int e_code, e_data;

  always @(posedge clk) begin
    if (!rst_n) begin
      e_ml = 0; e_sl = 0; e_er = 0; e_mv = 0; e_sv = 0; e_code = 0; e_data = 0;
    end else begin
      int c;
      bit ok_m, ok_s;
      c = int'(wr_data[12:8]);
      ok_m = wr_en && (c == 0 || c == 4 || c == 5 || c == 6) && !e_ml;
      ok_s = wr_en && (c == 16 || c == 22) && !e_sl;
      e_mv = ok_m;
      e_sv = ok_s;
      if (ok_m || ok_s) begin
        e_code = c % 16;
        e_data = int'(wr_data[7:0]);
      end
      e_er = (wr_en && !ok_m && !ok_s) || (e_er && !rd_en);
      e_ml = ok_m || (e_ml && !m_irq);
      e_sl = ok_s || (e_sl && !s_irq);
    end
  end

  task automatic check(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %0h expected %0h", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    string tag;
    tag = rst_n ? "" : "R1 ";
    check({tag, "R2"}, "m_cmd_vld", int'(m_cmd_vld), int'(e_mv));
    check({tag, "R2"}, "s_cmd_vld", int'(s_cmd_vld), int'(e_sv));
    check("R2", "cmd_code", int'(cmd_code), e_code);
    check("R2", "cmd_data", int'(cmd_data), e_data);
    check({tag, "R5"}, "master lock", int'(rd_data[8]), int'(e_ml));
    check({tag, "R5"}, "slave lock", int'(rd_data[9]), int'(e_sl));
    check({tag, "R7"}, "error flag", int'(rd_data[10]), int'(e_er));
    check("R10", "rx byte", int'(rd_data[7:0]), int'(rx_data));
  end

  task automatic step(bit w, int cmd, int dat, bit rd, bit mi, bit si, int rx);
    @(negedge clk); #1;
    wr_en = w; wr_data = {5'(cmd), 8'(dat)};
    rd_en = rd; m_irq = mi; s_irq = si; rx_data = 8'(rx);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 8'h3C + i);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);  // R1 reset state compared here
    #1 rst_n = 1'b1;
    idle(2);
    // R3 master write, then write while locked (R7)
    step(1, 'h05, 'hA5, 0, 0, 0, 'h11);
    step(1, 'h04, 'h5A, 0, 0, 0, 'h22);
    idle(1);
    // R9 read clears error; R6 irq releases lock
    step(0, 0, 0, 1, 1, 0, 'h33);
    idle(2);
    // R3 remaining master codes, each acknowledged
    step(1, 'h04, 'h01, 0, 0, 0, 0); step(0, 0, 0, 0, 1, 0, 0);
    step(1, 'h06, 'h02, 0, 0, 0, 0); step(0, 0, 0, 0, 1, 0, 0);
    step(1, 'h00, 'h03, 0, 0, 0, 0); step(0, 0, 0, 0, 1, 0, 0);
    idle(1);
    // R4 slave stop and slave no-op carrying data
    step(1, 'h16, 'hC3, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 1, 0);
    step(1, 'h10, 'h7E, 0, 0, 0, 0);
    // R7 slave locked, master accepted meanwhile
    step(1, 'h16, 'h99, 0, 0, 0, 0);
    step(1, 'h05, 'h44, 1, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1, 0);
    idle(1);
    // R8 undefined and cross-engine codes
    step(1, 'h07, 'h10, 1, 0, 0, 0);
    step(1, 'h14, 'h20, 0, 0, 0, 0);
    step(1, 'h15, 'h21, 0, 0, 0, 0);
    step(1, 'h01, 'h22, 0, 0, 0, 0);
    step(1, 'h1F, 'h23, 1, 0, 0, 0);   // R9 set wins over read
    step(0, 0, 0, 1, 0, 0, 0);
    step(1, 'h06, 'h24, 0, 0, 0, 0);   // R8 codes that name the master's set do not reach the slave
    step(0, 0, 0, 1, 1, 0, 0);
    // R6 irq in same cycle as accepted command keeps lock
    step(1, 'h04, 'h55, 0, 1, 0, 0);
    idle(2);
    // R7 locked target with releasing irq in same cycle: still rejected
    step(1, 'h05, 'h66, 0, 1, 0, 0);
    idle(1);
    step(1, 'h05, 'h67, 1, 0, 0, 0);
    step(1, 'h16, 'h68, 0, 0, 0, 0);
    step(0, 0, 0, 0, 1, 1, 0);
    idle(3);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule